// File: doc/BRIEF.md
# Bus Turnaround Gap Scheduler

This block sits between two back-to-back static memory transactions and decides how many idle clock cycles must pass before the next one may start. When the current transaction finishes, the block receives a one-cycle completion pulse. At the same moment it receives a description of the finished transaction and of the pending one. Each description gives the timing class (synchronous or asynchronous), the direction (read or write) and the bank index. The block also takes a shared multiplexed-address flag and a programmed turnaround count.

The required gap does not always equal the programmed count. An ordered list of rules picks a fixed gap of 0, 1, 2 or 3 cycles for certain pairs of transaction types. The programmed count applies only where no earlier rule matches. The chosen gap is loaded into a down-counter. The ready output stays low while the counter is non-zero, so the access sequencer holds off the next transaction until ready returns high.

Top module: `turnaround_gap_sched`

## Requirements
- R1: With the multiplexed flag low, an asynchronous write followed by an asynchronous write to the same bank gives a gap of 0 cycles.
- R2: With the multiplexed flag low, an asynchronous read followed by an asynchronous read to the same bank gives a gap of 1 cycle.
- R3: With the multiplexed flag low, an asynchronous read followed by any write (synchronous or asynchronous, any bank) gives a gap of 1 cycle.
- R4: A synchronous write followed by a synchronous write to the same bank gives a gap of 2 cycles.
- R5: A synchronous write followed by any asynchronous access gives a gap of 2 cycles.
- R6: A synchronous write followed by a synchronous write to a different bank gives a gap of 3 cycles.
- R7: A synchronous write followed by a synchronous read, to any bank, gives a gap of 3 cycles.
- R8: Any other pair whose finished transaction is asynchronous gives a gap equal to the programmed turnaround value (0 to 15). This includes every asynchronous pair when the multiplexed flag is high.
- R9: After a synchronous read, the gap is 2 cycles when the banks differ and 0 cycles when they match. The rules are evaluated in the order R1 to R9, and the first match decides the gap.
- R10: The completion pulse is sampled on a rising clock edge. When the gap is G > 0, ready is low for exactly G cycles, starting in the cycle that follows that edge. When G = 0, ready stays high. Ready never falls without a completion pulse.
- R11: A completion pulse that arrives while a countdown is running discards the remaining count and loads the newly computed gap, even when that gap is 0.
- R12: After reset, ready is high. Without a completion pulse, changes on the descriptor, multiplexed-flag and turnaround inputs have no effect on ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| done_i | input | 1 | One-cycle pulse marking the end of the finished transaction |
| prev_sync_i | input | 1 | Finished transaction was synchronous (1) or asynchronous (0) |
| prev_write_i | input | 1 | Finished transaction was a write (1) or a read (0) |
| prev_bank_i | input | BANK_W | Bank index of the finished transaction |
| next_sync_i | input | 1 | Pending transaction is synchronous (1) or asynchronous (0) |
| next_write_i | input | 1 | Pending transaction is a write (1) or a read (0) |
| next_bank_i | input | BANK_W | Bank index of the pending transaction |
| mux_mode_i | input | 1 | Multiplexed address/data mode active |
| turn_cfg_i | input | TURN_W | Programmed turnaround count |
| ready_o | output | 1 | High when the pending transaction may start |

## Verification
The only result is ready_o, and it is registered. A completion pulse sampled at rising edge t first affects ready in the cycle after t. For a gap G, ready is then low across the next G clock periods and returns high in the period after those. The bench keeps a behavioural count of remaining idle cycles, updated at each rising edge from the inputs driven half a period earlier. It compares ready against that count at every falling edge, so each result is read a full half period after the edge that produced it. Restart cases issue a second pulse partway through a long countdown, and the expected count is replaced at that same edge.

// File: rtl/tgs_pkg.sv
package tgs_pkg;

    // Which ordering rule picked the gap (first match wins, in this order)
    typedef enum logic [3:0] {
        RULE_AWR_SAME,
        RULE_ARD_SAME,
        RULE_ARD_TO_WR,
        RULE_SWR_SAME,
        RULE_SWR_TO_ASYNC,
        RULE_SWR_DIFF,
        RULE_SWR_TO_SRD,
        RULE_ASYNC_PROG,
        RULE_SRD_DIFF,
        RULE_SRD_SAME
    } gap_rule_e;

    typedef struct packed {
        logic sync;
        logic write;
    } acc_kind_t;

    // Fixed gap attached to each rule; the programmed rule returns 0 here
    function automatic logic [1:0] fixed_gap(input gap_rule_e rule);
        case (rule)
            RULE_ARD_SAME, RULE_ARD_TO_WR:              return 2'd1;
            RULE_SWR_SAME, RULE_SWR_TO_ASYNC,
            RULE_SRD_DIFF:                              return 2'd2;
            RULE_SWR_DIFF, RULE_SWR_TO_SRD:             return 2'd3;
            default:                                    return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/tgs_rule_sel.sv
module tgs_rule_sel
    import tgs_pkg::*;
#(
    parameter int TURN_W = 4
) (
    input  acc_kind_t         prev_kind_i,
    input  acc_kind_t         next_kind_i,
    input  logic              same_bank_i,
    input  logic              mux_mode_i,
    input  logic [TURN_W-1:0] turn_cfg_i,
    output logic [TURN_W-1:0] gap_o
);

    gap_rule_e rule_w;

    // Ordered rule list: first matching branch decides
    always_comb begin
        if (!prev_kind_i.sync && prev_kind_i.write && !next_kind_i.sync &&
            next_kind_i.write && same_bank_i && !mux_mode_i)
            rule_w = RULE_AWR_SAME;
        else if (!prev_kind_i.sync && !prev_kind_i.write && !next_kind_i.sync &&
                 !next_kind_i.write && same_bank_i && !mux_mode_i)
            rule_w = RULE_ARD_SAME;
        else if (!prev_kind_i.sync && !prev_kind_i.write && next_kind_i.write &&
                 !mux_mode_i)
            rule_w = RULE_ARD_TO_WR;
        else if (prev_kind_i.sync && prev_kind_i.write && next_kind_i.sync &&
                 next_kind_i.write && same_bank_i)
            rule_w = RULE_SWR_SAME;
        else if (prev_kind_i.sync && prev_kind_i.write && !next_kind_i.sync)
            rule_w = RULE_SWR_TO_ASYNC;
        else if (prev_kind_i.sync && prev_kind_i.write && next_kind_i.write)
            rule_w = RULE_SWR_DIFF;
        else if (prev_kind_i.sync && prev_kind_i.write)
            rule_w = RULE_SWR_TO_SRD;
        else if (!prev_kind_i.sync)
            rule_w = RULE_ASYNC_PROG;
        else if (!same_bank_i)
            rule_w = RULE_SRD_DIFF;
        else
            rule_w = RULE_SRD_SAME;
    end

    always_comb begin
        if (rule_w == RULE_ASYNC_PROG)
            gap_o = turn_cfg_i;
        else
            gap_o = TURN_W'(fixed_gap(rule_w));
    end

endmodule

// File: rtl/tgs_countdown.sv
module tgs_countdown #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             ready_o
);

    typedef struct packed {
        logic [CNT_W-1:0] remain;
    } cnt_state_t;

    cnt_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (load_i)
            state_d.remain = load_val_i;
        else if (state_q.remain != '0)
            state_d.remain = state_q.remain - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign ready_o = (state_q.remain == '0);

endmodule

// File: rtl/turnaround_gap_sched.sv
module turnaround_gap_sched
    import tgs_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int TURN_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  logic              prev_sync_i,
    input  logic              prev_write_i,
    input  logic [BANK_W-1:0] prev_bank_i,
    input  logic              next_sync_i,
    input  logic              next_write_i,
    input  logic [BANK_W-1:0] next_bank_i,
    input  logic              mux_mode_i,
    input  logic [TURN_W-1:0] turn_cfg_i,
    output logic              ready_o
);

    acc_kind_t         prev_kind_w, next_kind_w;
    logic              same_bank_w;
    logic [TURN_W-1:0] gap_w;

    assign prev_kind_w = '{sync: prev_sync_i, write: prev_write_i};
    assign next_kind_w = '{sync: next_sync_i, write: next_write_i};
    assign same_bank_w = (prev_bank_i == next_bank_i);

    tgs_rule_sel #(.TURN_W(TURN_W)) u_rule (
        .prev_kind_i (prev_kind_w),
        .next_kind_i (next_kind_w),
        .same_bank_i (same_bank_w),
        .mux_mode_i  (mux_mode_i),
        .turn_cfg_i  (turn_cfg_i),
        .gap_o       (gap_w)
    );

    tgs_countdown #(.CNT_W(TURN_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (done_i),
        .load_val_i (gap_w),
        .ready_o    (ready_o)
    );

endmodule

// File: rtl/tgs_checker.sv
module tgs_checker #(
    parameter int BANK_W = 2,
    parameter int TURN_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done_i,
    input logic              prev_sync_i,
    input logic              prev_write_i,
    input logic [BANK_W-1:0] prev_bank_i,
    input logic              next_sync_i,
    input logic              next_write_i,
    input logic [BANK_W-1:0] next_bank_i,
    input logic              mux_mode_i,
    input logic [TURN_W-1:0] gap_i,
    input logic              ready_o
);

    logic same_bank;
    assign same_bank = (prev_bank_i == next_bank_i);

    // R1: async write pair to one bank never drops ready
    p_awr_nogap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !prev_sync_i && prev_write_i && !next_sync_i && next_write_i &&
         same_bank && !mux_mode_i) |=> ready_o);

    // R2: async read pair to one bank: one low cycle, then high unless a new pulse came
    p_ard_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !prev_sync_i && !prev_write_i && !next_sync_i && !next_write_i &&
         same_bank && !mux_mode_i) ##1 !done_i |-> !ready_o ##1 ready_o);

    // R6: sync write pair across banks drops ready on the next cycle
    p_swr_diff_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && prev_sync_i && prev_write_i && next_sync_i && next_write_i &&
         !same_bank) |=> !ready_o);

    // R10: ready only falls after a completion pulse
    p_hold_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && !done_i) |=> ready_o);

    // R11: a pulse with a zero gap restores ready even mid-countdown
    p_restart_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && gap_i == '0) |=> ready_o);

    // R10: a non-zero gap always drops ready on the following cycle
    p_load_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && gap_i != '0) |=> !ready_o);

endmodule

bind turnaround_gap_sched tgs_checker #(.BANK_W(BANK_W), .TURN_W(TURN_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .done_i       (done_i),
    .prev_sync_i  (prev_sync_i),
    .prev_write_i (prev_write_i),
    .prev_bank_i  (prev_bank_i),
    .next_sync_i  (next_sync_i),
    .next_write_i (next_write_i),
    .next_bank_i  (next_bank_i),
    .mux_mode_i   (mux_mode_i),
    .gap_i        (gap_w),
    .ready_o      (ready_o)
);

// File: tb/turnaround_gap_sched_bench.sv
module turnaround_gap_sched_bench;

    localparam int BANK_W = 2;
    localparam int TURN_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic done_i = 1'b0;
    logic prev_sync_i = 1'b0, prev_write_i = 1'b0;
    logic next_sync_i = 1'b0, next_write_i = 1'b0;
    logic [BANK_W-1:0] prev_bank_i = '0, next_bank_i = '0;
    logic mux_mode_i = 1'b0;
    logic [TURN_W-1:0] turn_cfg_i = '0;
    logic ready_o;

    int total = 0;
    int bad = 0;
    int exp_rem = 0;
    string cur_tag = "R12";
    bit cmp_en = 1'b0;
    bit finished = 1'b0;

    always #10ns clk = ~clk;

    turnaround_gap_sched #(.BANK_W(BANK_W), .TURN_W(TURN_W)) u_turnaround_gap_sched (
        .clk(clk), .rst_n(rst_n), .done_i(done_i),
        .prev_sync_i(prev_sync_i), .prev_write_i(prev_write_i), .prev_bank_i(prev_bank_i),
        .next_sync_i(next_sync_i), .next_write_i(next_write_i), .next_bank_i(next_bank_i),
        .mux_mode_i(mux_mode_i), .turn_cfg_i(turn_cfg_i), .ready_o(ready_o)
    );

    // Expected gap written from the requirement list, first match wins
    function automatic int want_gap(output string tag);
        bit same = (prev_bank_i == next_bank_i);
        if (!prev_sync_i && !mux_mode_i) begin
            if (prev_write_i && !next_sync_i && next_write_i && same) begin tag = "R1"; return 0; end
            if (!prev_write_i && !next_sync_i && !next_write_i && same) begin tag = "R2"; return 1; end
            if (!prev_write_i && next_write_i) begin tag = "R3"; return 1; end
        end
        if (prev_sync_i && prev_write_i) begin
            if (next_sync_i && next_write_i && same) begin tag = "R4"; return 2; end
            if (!next_sync_i) begin tag = "R5"; return 2; end
            if (next_write_i) begin tag = "R6"; return 3; end
            tag = "R7"; return 3;
        end
        if (!prev_sync_i) begin tag = "R8"; return int'(turn_cfg_i); end
        tag = "R9";
        return same ? 0 : 2;
    endfunction

    // Behavioural model of the remaining idle cycles (R10, R11)
    always @(posedge clk) begin
        if (rst_n) begin
            if (done_i) begin
                string t;
                exp_rem = want_gap(t);
                cur_tag = t;
            end else if (exp_rem > 0) begin
                exp_rem = exp_rem - 1;
            end
        end
    end

    task automatic check(input logic got, input logic exp, input string tag);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s ready actual=%0b expected=%0b at %0t", tag, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en && !finished)
            check(ready_o, (exp_rem == 0), cur_tag);
    end

    task automatic send(input bit ps, input bit pw, input int pb,
                        input bit ns, input bit nw, input int nb,
                        input bit mx, input int turn, input int idle);
        prev_sync_i = ps; prev_write_i = pw; prev_bank_i = BANK_W'(pb);
        next_sync_i = ns; next_write_i = nw; next_bank_i = BANK_W'(nb);
        mux_mode_i = mx; turn_cfg_i = TURN_W'(turn);
        done_i = 1'b1;
        @(negedge clk);
        done_i = 1'b0;
        repeat (idle) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(20ns * 200000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(ready_o, 1'b1, "R12 reset");
        rst_n = 1'b1;
        @(negedge clk);
        cmp_en = 1'b1;
        // R12: descriptor changes without a pulse leave ready high
        prev_sync_i = 1'b1; next_bank_i = 2'd3; turn_cfg_i = 4'd9; mux_mode_i = 1'b1;
        repeat (3) @(negedge clk);
        // R1 / R8 write pairs, same and other bank, mux off and on
        send(0,1,1, 0,1,1, 0, 7, 4);
        send(0,1,1, 0,1,2, 0, 5, 7);
        send(0,1,2, 0,1,2, 1, 4, 6);
        // R2 / R3 after async read
        send(0,0,0, 0,0,0, 0, 9, 3);
        send(0,0,0, 1,1,3, 0, 9, 3);
        send(0,0,1, 0,1,2, 0, 9, 3);
        send(0,0,0, 0,0,0, 1, 6, 8);   // R8 multiplexed read pair
        send(0,0,0, 0,0,2, 0, 2, 4);   // R8 read to other bank
        send(0,0,3, 1,0,3, 0, 0, 3);   // R8 zero programmed value
        send(0,1,0, 1,0,1, 0, 15, 18); // R8 largest programmed value
        // Synchronous write rules R4 to R7
        send(1,1,2, 1,1,2, 0, 9, 4);
        send(1,1,2, 0,0,2, 0, 9, 4);
        send(1,1,2, 0,1,1, 1, 9, 4);
        send(1,1,0, 1,1,3, 0, 9, 5);
        send(1,1,0, 1,0,0, 0, 9, 5);
        send(1,1,0, 1,0,1, 1, 9, 5);
        // R9 after synchronous read
        send(1,0,1, 1,0,1, 0, 9, 3);
        send(1,0,1, 0,1,2, 0, 9, 4);
        send(1,0,1, 1,1,1, 1, 9, 3);
        // R11 restarts: long count cut by a shorter one, by a zero, by a longer one
        send(0,1,0, 0,0,0, 0, 12, 3);
        send(1,1,0, 1,1,1, 0, 0, 1);
        send(0,1,0, 1,1,0, 0, 10, 2);
        send(0,1,1, 0,1,1, 0, 3, 1);
        send(1,0,0, 1,0,2, 0, 0, 1);
        send(0,1,0, 0,1,3, 0, 13, 14);
        // back-to-back pulses on consecutive cycles
        send(1,1,0, 1,0,0, 0, 0, 0);
        send(0,0,0, 0,0,0, 0, 0, 0);
        send(0,1,0, 0,1,0, 1, 2, 4);
        cmp_en = 1'b0;
        finish_run();
    end

endmodule